// File: doc/BRIEF.md
# Memory-Controller Fault Logger

This block sits beside a memory controller and records the faults that the controller's fabric reports. Each cycle the fabric may present one fault event: an address decode error, a security violation (trust-zone or carve-out flavour), an arbitration error, or an access to an invalid translation page together with that page's permission bits. Every event sets a sticky bit in an interrupt-status register. Events that describe a specific access also load a syndrome word (type code, page permissions, secure and write flags, client ID) and the faulting address into two capture registers.

A level interrupt is raised whenever a status bit is set and the matching bit of an interrupt-mask register is also set. Software uses a small 32-bit register port to read all four registers, write the mask, and clear status bits. To clear status, software writes back the value it read: every 1 written clears that bit. The first fault that arrives while no enabled status bit is pending is held in the capture registers until software clears the enabled bits. Later faults still accumulate in the status register.

Top module: `mcf_fault_log`

## Requirements
- R1: After reset every register (status, mask, syndrome, address) reads zero and `irq` is low, so every interrupt source starts disabled.
- R2: Register byte offsets are status 0x0, mask 0x4, syndrome 0x8 and address 0xC (decoded from `reg_addr[3:2]`). `fault_kind` is encoded as 0 decode error, 1 trust-zone violation, 2 carve-out violation, 3 arbitration error, 4 invalid page. A fault sets status bit 6 (decode), bit 8 (either security kind), bit 9 (arbitration) or bit 10 (invalid page). All other status bits read zero.
- R3: Status bits are sticky. A write to the status offset clears exactly those bits written as 1; bits written as 0 are left unchanged.
- R4: Only mask bits 6, 8, 9 and 10 are writable; all other mask bits read zero. `irq` is high exactly when status AND mask is non-zero.
- R5: Syndrome bits 30:28 hold the fault type: 2 decode error, 3 trust-zone violation, 4 carve-out violation, 6 invalid page.
- R6: For invalid-page faults syndrome bits 27:25 hold `fault_perm` (bit 27 read, 26 write, 25 secure). For every other type these bits are zero.
- R7: Syndrome bit 16 copies `fault_write`, bit 17 copies `fault_secure`, and bits 6:0 copy the 7-bit client ID. The address register captures `fault_addr`. All other syndrome bits are zero.
- R8: A decode, security or invalid-page fault loads syndrome and address only if no enabled status bit is set in the cycle it arrives. Arbitration faults never load them.
- R9: When a fault and a status write that clears the same bit arrive in one cycle, the bit remains set.
- R10: The syndrome and address registers are read-only; writes to offsets 0x8 and 0xC change nothing.
- R11: A `fault_kind` of 5, 6 or 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_valid | input | 1 | A fault event is present this cycle |
| fault_kind | input | 3 | Fault class, encoded as in R2 |
| fault_perm | input | 3 | Page permissions {read, write, secure} for invalid-page faults |
| fault_secure | input | 1 | Faulting access was secure |
| fault_write | input | 1 | Faulting access was a write |
| fault_client | input | 7 | ID of the requesting client |
| fault_addr | input | 32 | Faulting address |
| reg_addr | input | REG_AW | Register byte address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
Some properties are checked on every cycle. Status bits stay set unless a status write occurs, and a fault's bit is always set on the next cycle, even when a clear arrives at the same time. The capture registers stay frozen while an enabled bit is pending and when software writes to them. Captured type codes are always legal, permission bits appear only with the invalid-page type, and the interrupt rises only after a fault or a mask write. Only the directed scenarios can show the exact bit positions, the syndrome packing for each fault kind, write-back clearing of partial patterns, mask gating of individual sources, and the first-fault capture order across several faults.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

    localparam int DATA_W   = 32;
    localparam int CLIENT_W = 7;
    localparam int N_SRC    = 4;

    // internal source index -> status bit position
    localparam int SRC_DEC  = 0;
    localparam int SRC_SEC  = 1;
    localparam int SRC_ARB  = 2;
    localparam int SRC_PAGE = 3;

    // syndrome layout
    localparam int TYPE_LSB = 28;
    localparam int PERM_LSB = 25;
    localparam int SEC_BIT  = 17;
    localparam int WR_BIT   = 16;

    typedef enum logic [2:0] {
        KIND_DECODE = 3'd0,
        KIND_TZONE  = 3'd1,
        KIND_CARVE  = 3'd2,
        KIND_ARB    = 3'd3,
        KIND_PAGE   = 3'd4
    } fault_kind_e;

    localparam logic [2:0] TYPE_NONE   = 3'd0;
    localparam logic [2:0] TYPE_DECODE = 3'd2;
    localparam logic [2:0] TYPE_TZONE  = 3'd3;
    localparam logic [2:0] TYPE_CARVE  = 3'd4;
    localparam logic [2:0] TYPE_PAGE   = 3'd6;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_SYND   = 2'd2,
        SEL_ADDR   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [N_SRC-1:0] sts;
        logic [N_SRC-1:0] msk;
    } status_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] syn;
        logic [DATA_W-1:0] adr;
    } capture_state_t;

    function automatic int src_pos(input int idx);
        case (idx)
            SRC_DEC:  return 6;
            SRC_SEC:  return 8;
            SRC_ARB:  return 9;
            default:  return 10;
        endcase
    endfunction

endpackage

// File: rtl/mcf_classify.sv
module mcf_classify
    import mcf_pkg::*;
(
    input  logic                evt_valid,
    input  logic [2:0]          evt_kind,
    input  logic [2:0]          evt_perm,
    input  logic                evt_secure,
    input  logic                evt_write,
    input  logic [CLIENT_W-1:0] evt_client,
    output logic [N_SRC-1:0]    src_hit,
    output logic                load_req,
    output logic [DATA_W-1:0]   syn_word
);

    logic [2:0] type_code;
    logic       keep_perm;

    always_comb begin
        src_hit   = '0;
        load_req  = 1'b0;
        type_code = TYPE_NONE;
        keep_perm = 1'b0;
        if (evt_valid) begin
            case (fault_kind_e'(evt_kind))
                KIND_DECODE: begin
                    src_hit[SRC_DEC] = 1'b1;
                    type_code        = TYPE_DECODE;
                    load_req         = 1'b1;
                end
                KIND_TZONE: begin
                    src_hit[SRC_SEC] = 1'b1;
                    type_code        = TYPE_TZONE;
                    load_req         = 1'b1;
                end
                KIND_CARVE: begin
                    src_hit[SRC_SEC] = 1'b1;
                    type_code        = TYPE_CARVE;
                    load_req         = 1'b1;
                end
                KIND_ARB: begin
                    src_hit[SRC_ARB] = 1'b1;
                end
                KIND_PAGE: begin
                    src_hit[SRC_PAGE] = 1'b1;
                    type_code         = TYPE_PAGE;
                    keep_perm         = 1'b1;
                    load_req          = 1'b1;
                end
                default: begin
                    src_hit = '0;
                end
            endcase
        end
    end

    always_comb begin
        syn_word                    = '0;
        syn_word[TYPE_LSB +: 3]     = type_code;
        syn_word[PERM_LSB +: 3]     = keep_perm ? evt_perm : 3'b000;
        syn_word[SEC_BIT]           = evt_secure;
        syn_word[WR_BIT]            = evt_write;
        syn_word[CLIENT_W-1:0]      = evt_client;
    end

endmodule

// File: rtl/mcf_status.sv
module mcf_status
    import mcf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_hit,
    input  logic             clr_we,
    input  logic [N_SRC-1:0] clr_bits,
    input  logic             msk_we,
    input  logic [N_SRC-1:0] msk_bits,
    output logic [N_SRC-1:0] sts_q,
    output logic [N_SRC-1:0] msk_q,
    output logic             irq
);

    status_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        if (clr_we) begin
            st_d.sts = st_q.sts & ~clr_bits;
        end
        // a new fault overrides a simultaneous clear
        st_d.sts = st_d.sts | src_hit;
        if (msk_we) begin
            st_d.msk = msk_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_q = st_q.sts;
    assign msk_q = st_q.msk;
    assign irq   = |(st_q.sts & st_q.msk);

    AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R3

    AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_hit) |=> ((sts_q & $past(src_hit)) == $past(src_hit))); // R9

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((|src_hit) || msk_we)); // R4

endmodule

// File: rtl/mcf_capture.sv
module mcf_capture
    import mcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic              hold,
    input  logic [DATA_W-1:0] syn_word,
    input  logic [DATA_W-1:0] evt_addr,
    output logic [DATA_W-1:0] syn_q,
    output logic [DATA_W-1:0] adr_q
);

    capture_state_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (load_req && !hold) begin
            cap_d.syn = syn_word;
            cap_d.adr = evt_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign syn_q = cap_q.syn;
    assign adr_q = cap_q.adr;

    AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(syn_q) && $stable(adr_q))); // R8

    AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_q[TYPE_LSB +: 3] == TYPE_NONE)   || (syn_q[TYPE_LSB +: 3] == TYPE_DECODE) ||
        (syn_q[TYPE_LSB +: 3] == TYPE_TZONE)  || (syn_q[TYPE_LSB +: 3] == TYPE_CARVE)  ||
        (syn_q[TYPE_LSB +: 3] == TYPE_PAGE)); // R5

    AST_PERM_PAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_q[TYPE_LSB +: 3] != TYPE_PAGE) |-> (syn_q[PERM_LSB +: 3] == 3'b000)); // R6

endmodule

// File: rtl/mcf_fault_log.sv
module mcf_fault_log
    import mcf_pkg::*;
#(
    parameter int REG_AW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fault_valid,
    input  logic [2:0]          fault_kind,
    input  logic [2:0]          fault_perm,
    input  logic                fault_secure,
    input  logic                fault_write,
    input  logic [CLIENT_W-1:0] fault_client,
    input  logic [DATA_W-1:0]   fault_addr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic                reg_wen,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq
);

    localparam int SEL_LSB = 2;

    logic [N_SRC-1:0]  src_hit;
    logic              load_req;
    logic [DATA_W-1:0] syn_word;
    logic [N_SRC-1:0]  sts_q, msk_q;
    logic [N_SRC-1:0]  wr_bits;
    logic [DATA_W-1:0] sts_word, msk_word;
    logic [DATA_W-1:0] syn_q, adr_q;
    reg_sel_e          sel;
    logic              clr_we, msk_we;
    logic              unused_inputs;

    assign sel    = reg_sel_e'(reg_addr[SEL_LSB +: 2]);
    assign clr_we = reg_wen && (sel == SEL_STATUS);
    assign msk_we = reg_wen && (sel == SEL_MASK);
    assign unused_inputs = ^{reg_addr, reg_wdata};

    // compress write data and expand stored bits onto their register positions
    always_comb begin
        wr_bits  = '0;
        sts_word = '0;
        msk_word = '0;
        for (int i = 0; i < N_SRC; i++) begin
            wr_bits[i]           = reg_wdata[src_pos(i)];
            sts_word[src_pos(i)] = sts_q[i];
            msk_word[src_pos(i)] = msk_q[i];
        end
    end

    mcf_classify u_classify (
        .evt_valid  (fault_valid),
        .evt_kind   (fault_kind),
        .evt_perm   (fault_perm),
        .evt_secure (fault_secure),
        .evt_write  (fault_write),
        .evt_client (fault_client),
        .src_hit    (src_hit),
        .load_req   (load_req),
        .syn_word   (syn_word)
    );

    mcf_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_hit  (src_hit),
        .clr_we   (clr_we),
        .clr_bits (wr_bits),
        .msk_we   (msk_we),
        .msk_bits (wr_bits),
        .sts_q    (sts_q),
        .msk_q    (msk_q),
        .irq      (irq)
    );

    mcf_capture u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (load_req),
        .hold     (irq),
        .syn_word (syn_word),
        .evt_addr (fault_addr),
        .syn_q    (syn_q),
        .adr_q    (adr_q)
    );

    always_comb begin
        case (sel)
            SEL_STATUS: reg_rdata = sts_word;
            SEL_MASK:   reg_rdata = msk_word;
            SEL_SYND:   reg_rdata = syn_q;
            default:    reg_rdata = adr_q;
        endcase
    end

    AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_hit)); // R2

    AST_CAPTURE_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && !fault_valid && ((sel == SEL_SYND) || (sel == SEL_ADDR)))
        |=> ($stable(syn_q) && $stable(adr_q))); // R10

    AST_UNDEF_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && (fault_kind > 3'd4) && !reg_wen)
        |=> ($stable(sts_q) && $stable(syn_q) && $stable(adr_q))); // R11

endmodule

// File: tb/sim_mcf_fault_log.sv
module sim_mcf_fault_log;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_valid = 1'b0;
    logic [2:0]  fault_kind = 3'd0;
    logic [2:0]  fault_perm = 3'd0;
    logic        fault_secure = 1'b0;
    logic        fault_write = 1'b0;
    logic [6:0]  fault_client = 7'd0;
    logic [31:0] fault_addr = 32'd0;
    logic [3:0]  reg_addr = 4'd0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    mcf_fault_log u0 (
        .clk(clk), .rst_n(rst_n),
        .fault_valid(fault_valid), .fault_kind(fault_kind), .fault_perm(fault_perm),
        .fault_secure(fault_secure), .fault_write(fault_write),
        .fault_client(fault_client), .fault_addr(fault_addr),
        .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] syn(input logic [2:0] t, input logic [2:0] p,
                                        input logic s, input logic w, input logic [6:0] c);
        return (32'(t) << 28) | (32'(p) << 25) | (32'(s) << 17) | (32'(w) << 16) | 32'(c);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // one clock of stimulus, driven at the falling edge; results visible at the next falling edge
    task automatic step(input logic fv, input logic [2:0] k, input logic [2:0] p,
                        input logic s, input logic w, input logic [6:0] c, input logic [31:0] fa,
                        input logic we, input logic [3:0] wa, input logic [31:0] wd);
        @(negedge clk);
        fault_valid = fv; fault_kind = k; fault_perm = p; fault_secure = s;
        fault_write = w; fault_client = c; fault_addr = fa;
        reg_wen = we; reg_addr = wa; reg_wdata = wd;
        @(negedge clk);
        fault_valid = 1'b0; reg_wen = 1'b0;
    endtask

    task automatic fault(input logic [2:0] k, input logic [2:0] p, input logic s,
                         input logic w, input logic [6:0] c, input logic [31:0] fa);
        step(1'b1, k, p, s, w, c, fa, 1'b0, 4'h0, 32'd0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        step(1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 7'd0, 32'd0, 1'b1, a, d);
    endtask

    task automatic clear_all();
        logic [31:0] v;
        rd(4'h0, v);
        wr(4'h0, v);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(4'(a * 4), v);
            chk("R1 register reset", v, 32'd0);
        end
        chk("R1 irq reset", 32'(irq), 32'd0);
    endtask

    task automatic t_classes();
        logic [31:0] v;
        fault(3'd0, 3'b101, 1'b1, 1'b0, 7'd5, 32'h1000_0040);
        rd(4'h0, v); chk("R2 decode status bit 6", v, 32'h40);
        rd(4'h8, v); chk("R5 R6 R7 decode syndrome", v, syn(3'd2, 3'd0, 1'b1, 1'b0, 7'd5));
        rd(4'hC, v); chk("R7 decode address", v, 32'h1000_0040);
        chk("R4 irq masked off", 32'(irq), 32'd0);
        clear_all();
        rd(4'h0, v); chk("R3 write-back clears", v, 32'd0);

        fault(3'd1, 3'd0, 1'b0, 1'b1, 7'd65, 32'h2000_0000);
        rd(4'h0, v); chk("R2 trust-zone status bit 8", v, 32'h100);
        rd(4'h8, v); chk("R5 R7 trust-zone syndrome", v, syn(3'd3, 3'd0, 1'b0, 1'b1, 7'd65));
        clear_all();

        fault(3'd2, 3'b111, 1'b1, 1'b1, 7'd12, 32'h3000_0010);
        rd(4'h0, v); chk("R2 carve-out status bit 8", v, 32'h100);
        rd(4'h8, v); chk("R5 R6 carve-out syndrome", v, syn(3'd4, 3'd0, 1'b1, 1'b1, 7'd12));
        clear_all();

        fault(3'd4, 3'b110, 1'b0, 1'b0, 7'd33, 32'h4000_0080);
        rd(4'h0, v); chk("R2 invalid page status bit 10", v, 32'h400);
        rd(4'h8, v); chk("R6 invalid page permissions", v, syn(3'd6, 3'b110, 1'b0, 1'b0, 7'd33));
        rd(4'hC, v); chk("R7 invalid page address", v, 32'h4000_0080);
        clear_all();

        fault(3'd3, 3'b111, 1'b1, 1'b1, 7'd9, 32'h5000_0000);
        rd(4'h0, v); chk("R2 arbitration status bit 9", v, 32'h200);
        rd(4'h8, v); chk("R8 arbitration leaves syndrome", v, syn(3'd6, 3'b110, 1'b0, 1'b0, 7'd33));
        rd(4'hC, v); chk("R8 arbitration leaves address", v, 32'h4000_0080);
        clear_all();
    endtask

    task automatic t_undefined();
        logic [31:0] v;
        for (int k = 5; k < 8; k++) begin
            fault(3'(k), 3'b111, 1'b1, 1'b1, 7'd3, 32'hDEAD_0000);
            rd(4'h0, v); chk("R11 undefined kind status", v, 32'd0);
            rd(4'h8, v); chk("R11 undefined kind syndrome", v, syn(3'd6, 3'b110, 1'b0, 1'b0, 7'd33));
        end
    endtask

    task automatic t_mask_irq();
        logic [31:0] v;
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, v); chk("R4 mask writable bits", v, 32'h740);
        chk("R4 irq idle", 32'(irq), 32'd0);
        wr(4'h4, 32'h40);
        fault(3'd3, 3'd0, 1'b0, 1'b0, 7'd1, 32'h0);
        chk("R4 disabled source no irq", 32'(irq), 32'd0);
        fault(3'd0, 3'd0, 1'b0, 1'b0, 7'd2, 32'h0000_0100);
        chk("R4 enabled source irq", 32'(irq), 32'd1);
        wr(4'h0, 32'h40);
        chk("R4 irq drops after clear", 32'(irq), 32'd0);
        rd(4'h0, v); chk("R3 other bit stays", v, 32'h200);
        clear_all();
    endtask

    task automatic t_first_capture();
        logic [31:0] v;
        wr(4'h4, 32'h740);
        fault(3'd0, 3'd0, 1'b0, 1'b1, 7'd1, 32'h0000_00A0);
        fault(3'd1, 3'd0, 1'b1, 1'b0, 7'd2, 32'h0000_00B0);
        rd(4'h0, v); chk("R8 status accumulates", v, 32'h140);
        rd(4'h8, v); chk("R8 first syndrome kept", v, syn(3'd2, 3'd0, 1'b0, 1'b1, 7'd1));
        rd(4'hC, v); chk("R8 first address kept", v, 32'h0000_00A0);
        clear_all();
        chk("R4 irq after clear", 32'(irq), 32'd0);
        fault(3'd1, 3'd0, 1'b1, 1'b0, 7'd2, 32'h0000_00B0);
        rd(4'h8, v); chk("R8 capture after clear", v, syn(3'd3, 3'd0, 1'b1, 1'b0, 7'd2));
        rd(4'hC, v); chk("R8 address after clear", v, 32'h0000_00B0);
        clear_all();
        wr(4'h4, 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        fault(3'd0, 3'd0, 1'b0, 1'b0, 7'd4, 32'h10);
        step(1'b1, 3'd0, 3'd0, 1'b0, 1'b0, 7'd4, 32'h10, 1'b1, 4'h0, 32'h40);
        rd(4'h0, v); chk("R9 fault wins over clear", v, 32'h40);
        fault(3'd1, 3'd0, 1'b0, 1'b0, 7'd4, 32'h10);
        wr(4'h0, 32'h100);
        rd(4'h0, v); chk("R3 partial clear", v, 32'h40);
        wr(4'h0, 32'h0);
        rd(4'h0, v); chk("R3 zero write keeps bits", v, 32'h40);
        clear_all();
    endtask

    task automatic t_readonly();
        logic [31:0] s0, a0, v;
        rd(4'h8, s0);
        rd(4'hC, a0);
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'hC, 32'h1234_5678);
        rd(4'h8, v); chk("R10 syndrome read-only", v, s0);
        rd(4'hC, v); chk("R10 address read-only", v, a0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_classes();
        t_undefined();
        t_mask_irq();
        t_first_capture();
        t_race();
        t_readonly();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule